// File: doc/BRIEF.md
# Overlapped 15-Clock Serial ADC Master

This block drives a 12-bit serial analog-to-digital converter without pause, using 15 serial clocks per conversion instead of the usual 16. While `enable` is high it keeps the converter selected across back-to-back frames. It builds the serial clock from the system clock, using two separate phase counters set by parameters. In each frame it shifts an 8-bit control word out MSB first. At the same time it collects the 12-bit result, MSB first.

The first result bits of a conversion arrive late in the frame that started it. The last six bits arrive during the first six serial clocks of the next frame, while that frame's control word is already being sent. The block therefore reports each sample one frame late. It tags the sample with the channel of the frame that started the conversion. Settings are taken from the user-side inputs once per frame. Dropping `enable` lets the current frame finish and then deselects the converter. The result still in flight at that point is discarded.

Top module: `adc_overlap_master`

## Requirements
- R1: `adc_cs_n` goes low on the first system clock edge that sees `enable` high while idle, and stays low while frames run. Each frame is exactly 15 DCLK rising edges. After `enable` falls, `adc_cs_n` rises on the DCLK falling edge that ends the current frame, and DCLK stays low whenever `adc_cs_n` is high.
- R2: On rising edges 1 to 8 of a frame, DIN carries 1 (start), chan[2], chan[1], chan[0], mode, sgl_dif, pd[1], pd[0], in that order. DIN is 0 on rising edges 9 to 15.
- R3: DIN changes only on the system edge where DCLK falls or `adc_cs_n` falls. It is therefore stable for the whole low phase before each rising edge and for the whole high phase after it.
- R4: Every DCLK high phase lasts exactly HI_CYC system cycles and every low phase lasts exactly LO_CYC. The first rising edge comes LO_CYC cycles after `adc_cs_n` falls.
- R5: DOUT is sampled on rising edges 10 to 15 of a frame as result bits 11 to 6, and on rising edges 1 to 6 of the next frame as bits 5 to 0.
- R6: `smp_valid` is a one-cycle pulse, raised on the system edge of the 6th DCLK rising edge of a frame. `smp_data` then holds the result of the conversion started by the previous frame.
- R7: `smp_chan` equals the channel bits of the control word of the frame that started the reported conversion, not those of the current frame.
- R8: All configuration inputs are latched together, at the first enabled edge and at the system edge of each frame's 15th DCLK rising edge. Changes at any other time affect only the next frame.
- R9: No sample is reported in the first frame after `enable` rises. A run of N frames yields exactly N-1 samples, and the last frame's result is dropped.
- R10: During and after reset, with `enable` low, `adc_cs_n` is 1 and `adc_dclk`, `adc_din` and `smp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run continuous conversion frames while high |
| cfg_chan | input | 3 | Channel address for the next frame |
| cfg_mode | input | 1 | Conversion mode bit for the next frame |
| cfg_sgl_dif | input | 1 | Single-ended/differential select for the next frame |
| cfg_pd | input | 2 | Power-down bits for the next frame |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_dclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Serial control data to the converter |
| adc_dout | input | 1 | Serial result data from the converter |
| smp_valid | output | 1 | One-cycle strobe for a completed sample |
| smp_data | output | 12 | Sample value |
| smp_chan | output | 3 | Channel the sample was converted from |

## Verification
The hardest case to reach from the ports is a settings change that lands on the very system edge where the frame boundary latches the settings. In that case the channel tag and the control word must disagree by exactly one frame. The stimulus handles this by changing the settings one nanosecond after randomly chosen DCLK rising edges, including the 14th and 15th of a frame, so that both sides of the latch edge are covered. The behavioural converter model returns a value built from the control word it actually received plus the frame index, so a stale tag or misplaced bit shows as a mismatch. Directed runs also stop on the 3rd and the 15th rising edge of a frame, and run single-frame and two-frame sessions to cover the first-frame suppression.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  localparam int CTRL_W         = 8;
  localparam int RES_W          = 12;
  localparam int CHAN_W         = 3;
  localparam int FRAME_CLKS     = RES_W + 3;
  localparam int FIRST_RES_SLOT = CTRL_W + 1;
  localparam int LAST_RES_SLOT  = RES_W - (FRAME_CLKS - FIRST_RES_SLOT) - 1;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              mode;
    logic              sgl;
    logic [1:0]        pd;
  } adcm_cfg_t;

  function automatic logic [CTRL_W-1:0] adcm_ctrl_word(input adcm_cfg_t c);
    return {1'b1, c.chan, c.mode, c.sgl, c.pd};
  endfunction
endpackage

// File: rtl/adcm_dclk_gen.sv
module adcm_dclk_gen #(
  parameter int HI_CYC = 40,
  parameter int LO_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic at_boundary,
  output logic active,
  output logic dclk,
  output logic start_now,
  output logic rise_now,
  output logic fall_now,
  output logic stop_now
);
  localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    start_now = !active && enable;
    rise_now  = active && !dclk && (cnt == CW'(LO_CYC - 1));
    fall_now  = active && dclk && (cnt == CW'(HI_CYC - 1));
    stop_now  = fall_now && at_boundary && !enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      dclk   <= 1'b0;
      cnt    <= '0;
    end else if (start_now) begin
      active <= 1'b1;
      dclk   <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (rise_now) begin
        dclk <= 1'b1;
        cnt  <= '0;
      end else if (fall_now) begin
        dclk <= 1'b0;
        cnt  <= '0;
        if (stop_now) active <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R4: a rising edge of the serial clock only ever happens inside a run
  p_rise_in_run_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk) |-> active);

  // R1: leaving a run always happens with the serial clock returning low
  p_stop_clock_low_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> !dclk);
endmodule

// File: rtl/adcm_frame_seq.sv
module adcm_frame_seq
  import adcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_now,
  input  logic              rise_now,
  input  logic              fall_now,
  input  logic              stop_now,
  input  adcm_cfg_t         cfg_in,
  output logic [$clog2(FRAME_CLKS)-1:0] slot,
  output logic              at_boundary,
  output logic              din,
  output logic [CHAN_W-1:0] prev_chan,
  output logic              prev_ok
);
  localparam int SW = $clog2(FRAME_CLKS);
  localparam int BW = $clog2(CTRL_W);

  adcm_cfg_t         cfg_q;
  logic [CTRL_W-1:0] word_lat;
  logic [BW-1:0]     bit_ix;
  logic              last_slot;
  logic              in_ctrl;

  always_comb begin
    word_lat    = adcm_ctrl_word(cfg_q);
    last_slot   = (slot == SW'(FRAME_CLKS - 1));
    in_ctrl     = (slot < SW'(CTRL_W));
    bit_ix      = BW'(CTRL_W - 1 - int'(slot));
    at_boundary = (slot == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      cfg_q     <= '0;
      din       <= 1'b0;
      prev_chan <= '0;
      prev_ok   <= 1'b0;
    end else if (start_now) begin
      slot    <= '0;
      cfg_q   <= cfg_in;
      din     <= 1'b1;
      prev_ok <= 1'b0;
    end else begin
      if (rise_now) begin
        if (last_slot) begin
          slot      <= '0;
          cfg_q     <= cfg_in;
          prev_chan <= cfg_q.chan;
          prev_ok   <= 1'b1;
        end else begin
          slot <= slot + SW'(1);
        end
      end
      if (fall_now) begin
        if (stop_now)     din <= 1'b0;
        else if (in_ctrl) din <= word_lat[bit_ix];
        else              din <= 1'b0;
      end
    end
  end

  // R2: first rising edge of every frame carries the start bit
  p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (rise_now && at_boundary) |-> din);

  // R2: DIN is quiet during the result-only part of the frame
  p_tail_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (rise_now && !in_ctrl) |-> !din);

  // R9: a fresh run never inherits a completed frame
  p_fresh_run_r9: assert property (@(posedge clk) disable iff (rst)
    start_now |=> !prev_ok);
endmodule

// File: rtl/adcm_capture.sv
module adcm_capture
  import adcm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rise_now,
  input  logic [$clog2(FRAME_CLKS)-1:0] slot,
  input  logic                          dout,
  input  logic [CHAN_W-1:0]             prev_chan,
  input  logic                          prev_ok,
  output logic                          valid,
  output logic [RES_W-1:0]              data,
  output logic [CHAN_W-1:0]             chan
);
  localparam int SW = $clog2(FRAME_CLKS);

  logic [RES_W-1:0] sh;
  logic             take;
  logic             done;

  always_comb begin
    take = rise_now && ((slot >= SW'(FIRST_RES_SLOT)) || (slot <= SW'(LAST_RES_SLOT)));
    done = rise_now && (slot == SW'(LAST_RES_SLOT)) && prev_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      valid <= 1'b0;
      data  <= '0;
      chan  <= '0;
    end else begin
      if (take) sh <= {sh[RES_W-2:0], dout};
      valid <= done;
      if (done) begin
        data <= {sh[RES_W-2:0], dout};
        chan <= prev_chan;
      end
    end
  end

  // R6: a sample strobe never lasts longer than one cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R9: a strobe needs a previously completed control frame
  p_valid_after_frame_r9: assert property (@(posedge clk) disable iff (rst)
    valid |-> prev_ok);
endmodule

// File: rtl/adc_overlap_master.sv
module adc_overlap_master
  import adcm_pkg::*;
#(
  parameter int HI_CYC = 40,
  parameter int LO_CYC = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              cfg_mode,
  input  logic              cfg_sgl_dif,
  input  logic [1:0]        cfg_pd,
  output logic              adc_cs_n,
  output logic              adc_dclk,
  output logic              adc_din,
  input  logic              adc_dout,
  output logic              smp_valid,
  output logic [RES_W-1:0]  smp_data,
  output logic [CHAN_W-1:0] smp_chan
);
  localparam int SW = $clog2(FRAME_CLKS);

  adcm_cfg_t         cfg_in;
  logic              active, start_now, rise_now, fall_now, stop_now;
  logic              at_boundary, prev_ok;
  logic [SW-1:0]     slot;
  logic [CHAN_W-1:0] prev_chan;

  always_comb begin
    cfg_in.chan = cfg_chan;
    cfg_in.mode = cfg_mode;
    cfg_in.sgl  = cfg_sgl_dif;
    cfg_in.pd   = cfg_pd;
    adc_cs_n    = !active;
  end

  adcm_dclk_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_clk (
    .clk(clk), .rst(rst), .enable(enable), .at_boundary(at_boundary),
    .active(active), .dclk(adc_dclk), .start_now(start_now),
    .rise_now(rise_now), .fall_now(fall_now), .stop_now(stop_now)
  );

  adcm_frame_seq u_seq (
    .clk(clk), .rst(rst), .start_now(start_now), .rise_now(rise_now),
    .fall_now(fall_now), .stop_now(stop_now), .cfg_in(cfg_in), .slot(slot),
    .at_boundary(at_boundary), .din(adc_din), .prev_chan(prev_chan),
    .prev_ok(prev_ok)
  );

  adcm_capture u_cap (
    .clk(clk), .rst(rst), .rise_now(rise_now), .slot(slot), .dout(adc_dout),
    .prev_chan(prev_chan), .prev_ok(prev_ok), .valid(smp_valid),
    .data(smp_data), .chan(smp_chan)
  );

  // R1: the serial clock idles low whenever the converter is deselected
  p_idle_clock_low_r1: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_dclk);

  // R3: DIN only moves while the serial clock is low
  p_din_moves_low_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(adc_din) |-> !adc_dclk);

  // R3: DIN is held across every rising edge
  p_din_held_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_dclk) |-> $stable(adc_din));

  // R6: the sample strobe coincides with a serial clock rising edge
  p_valid_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $rose(adc_dclk));
endmodule

// File: tb/tb_adc_overlap_master.sv
`timescale 1ns/1ps
module tb_adc_overlap_master;
  localparam int TB_HI = 3;
  localparam int TB_LO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [2:0] cfg_chan = '0;
  logic cfg_mode = 1'b0, cfg_sgl = 1'b0;
  logic [1:0] cfg_pd = '0;
  logic adc_cs_n, adc_dclk, adc_din, smp_valid;
  logic adc_dout = 1'b0;
  logic [11:0] smp_data;
  logic [2:0] smp_chan;

  always #2.5 clk = ~clk;

  adc_overlap_master #(.HI_CYC(TB_HI), .LO_CYC(TB_LO)) dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_chan(cfg_chan),
    .cfg_mode(cfg_mode), .cfg_sgl_dif(cfg_sgl), .cfg_pd(cfg_pd),
    .adc_cs_n(adc_cs_n), .adc_dclk(adc_dclk), .adc_din(adc_din),
    .adc_dout(adc_dout), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  int rise_cnt = 0, rel = 0, fidx = 0;
  int cs_fall_cyc = 0, rise_cyc = 0, fall_cyc = 0, din_chg_cyc = 0, rise6_cyc = -10;
  int n_valid = 0;
  bit rand_on = 1'b0;
  bit last_valid = 1'b0;
  logic [7:0] rx_ctrl = '0, exp_ctrl = '0, nxt_ctrl = '0;
  logic [11:0] cur_val = '0, prev_val = '0;
  logic [14:0] expq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] mk_ctrl(input logic [2:0] ch, input logic md,
                                         input logic sg, input logic [1:0] pd);
    return {1'b1, ch, md, sg, pd};
  endfunction

  function automatic logic [11:0] model_val(input logic [7:0] c, input int f);
    return {c[6:0], 5'(f)};
  endfunction

  always @(posedge clk) cyc = cyc + 1;
  always @(adc_din) din_chg_cyc = cyc;
  always @(negedge adc_cs_n) begin
    rise_cnt = 0;
    cs_fall_cyc = cyc;
  end

  // behavioural converter: control capture and timing checks on rising edges
  always @(posedge adc_dclk) if (adc_cs_n === 1'b0) begin
    rise_cnt++;
    rel  = (rise_cnt - 1) % 15 + 1;
    fidx = (rise_cnt - 1) / 15;
    if (rise_cnt == 1) check(cyc - cs_fall_cyc == TB_LO, "R4 first rise delay", cyc - cs_fall_cyc, TB_LO);
    else               check(cyc - fall_cyc == TB_LO, "R4 low phase", cyc - fall_cyc, TB_LO);
    check(cyc - din_chg_cyc >= TB_LO, "R3 din setup", cyc - din_chg_cyc, TB_LO);
    if (rel == 1) begin
      exp_ctrl = (fidx == 0) ? mk_ctrl(cfg_chan, cfg_mode, cfg_sgl, cfg_pd) : nxt_ctrl;
      prev_val = cur_val;
    end
    if (rel <= 8) rx_ctrl = {rx_ctrl[6:0], adc_din};
    else check(adc_din == 1'b0, "R2 din low after control", int'(adc_din), 0);
    if (rel == 8) begin
      check(rx_ctrl == exp_ctrl, "R2 R8 control word", int'(rx_ctrl), int'(exp_ctrl));
      cur_val = model_val(rx_ctrl, fidx);
      expq.push_back({exp_ctrl[6:4], model_val(exp_ctrl, fidx)});
    end
    if (rel == 15) nxt_ctrl = mk_ctrl(cfg_chan, cfg_mode, cfg_sgl, cfg_pd);
    if (rel == 6) rise6_cyc = cyc;
    rise_cyc = cyc;
  end

  // behavioural converter: result bits change after falling edges
  always @(negedge adc_dclk) if (adc_cs_n === 1'b0) begin
    check(cyc - rise_cyc == TB_HI, "R4 high phase", cyc - rise_cyc, TB_HI);
    check((din_chg_cyc == cyc) || (din_chg_cyc <= rise_cyc), "R3 din hold", din_chg_cyc, rise_cyc);
    fall_cyc = cyc;
    #2;
    if (rel >= 9)                        adc_dout = cur_val[11 - (rel - 9)];
    else if (rel <= 5 && rise_cnt > 15)  adc_dout = prev_val[5 - rel];
    else                                 adc_dout = 1'($urandom);
  end

  // random settings changes just after serial rising edges, incl. frame boundary
  always @(posedge adc_dclk) if (rand_on) begin
    #1;
    if ($urandom_range(2) == 0) begin
      logic [31:0] r;
      r = $urandom;
      cfg_chan = r[2:0]; cfg_mode = r[3]; cfg_sgl = r[4]; cfg_pd = r[6:5];
    end
  end

  // sample scoreboard
  always @(negedge clk) if (!rst) begin
    if (smp_valid) begin
      n_valid++;
      check(!last_valid, "R6 single cycle strobe", 1, 0);
      check(cyc == rise6_cyc, "R6 strobe on 6th rise", cyc, rise6_cyc);
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected sample", int'(smp_data), 0);
      end else begin
        logic [14:0] e;
        e = expq.pop_front();
        check(smp_data == e[11:0], "R5 sample data", int'(smp_data), int'(e[11:0]));
        check(smp_chan == e[14:12], "R7 channel tag", int'(smp_chan), int'(e[14:12]));
      end
    end
    last_valid = smp_valid;
  end

  task automatic run_session(input int nframes, input int stop_rise);
    logic [31:0] r;
    @(negedge clk);
    r = $urandom;
    cfg_chan = r[2:0]; cfg_mode = r[3]; cfg_sgl = r[4]; cfg_pd = r[6:5];
    n_valid = 0;
    expq.delete();
    enable = 1'b1;
    @(negedge clk);
    check(adc_cs_n == 1'b0, "R1 select on enable", int'(adc_cs_n), 0);
    rand_on = 1'b1;
    while (rise_cnt < stop_rise) @(posedge clk);
    @(negedge clk);
    enable = 1'b0;
    while (adc_cs_n == 1'b0) @(posedge clk);
    rand_on = 1'b0;
    @(negedge clk);
    check(rise_cnt == 15 * nframes, "R1 frame count at stop", rise_cnt, 15 * nframes);
    check(adc_dclk == 1'b0 && adc_din == 1'b0, "R1 idle lines after stop",
          int'({adc_dclk, adc_din}), 0);
    check(n_valid == nframes - 1, "R9 samples per run", n_valid, nframes - 1);
    check(expq.size() == 1, "R9 last result dropped", expq.size(), 1);
    repeat (6) @(negedge clk);
    check(adc_cs_n == 1'b1 && smp_valid == 1'b0, "R1 stays idle",
          int'({adc_cs_n, smp_valid}), 2);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check(adc_cs_n == 1'b1, "R10 cs_n in reset", int'(adc_cs_n), 1);
    check(adc_dclk == 1'b0 && adc_din == 1'b0 && smp_valid == 1'b0,
          "R10 outputs in reset", int'({adc_dclk, adc_din, smp_valid}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(adc_cs_n == 1'b1 && adc_dclk == 1'b0 && adc_din == 1'b0 && smp_valid == 1'b0,
          "R10 idle after reset", int'({adc_cs_n, adc_dclk, adc_din, smp_valid}), 8);
    run_session(40, 15 * 39 + 3);   // long run, stop early in last frame
    run_session(12, 15 * 12);       // stop requested right at the 15th rise
    run_session(2, 15 + 1);         // shortest run with one sample
    run_session(1, 2);              // single frame: no sample at all
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule